// File: doc/BRIEF.md
# Double-Buffered Receive Packet Buffer

This block sits between a USB serial engine and a CPU on the receive side of a data endpoint. The engine pushes the bytes of a packet one at a time and closes each packet with an end-of-packet strobe that says whether the packet is good. Good packets are kept in one of two banks. The CPU then drains the current packet one byte per read strobe and releases the bank when it is done.

When double buffering is on, the block holds two complete packets. Releasing the first one makes the second one current at once: the ready status stays high and a fresh receive event is raised. A full flag shows that both banks are occupied, and the engine-side ready output is held low so that the engine refuses further packets. An optional auto-release mode frees the bank by itself when the CPU has read a programmed maximum packet size. Bad packets and packets longer than one bank are dropped without trace.

Top module: `rx_pkt_buf`

## Requirements
- R1: After reset, pkt_rdy_o, fifo_full_o, rx_evt_o, byte_cnt_o and cpu_data_o are 0 and eng_rdy_o is 1.
- R2: A good end-of-packet (eng_eop_i=1, eng_bad_i=0) while eng_rdy_o=1 stores the packet. A byte offered with eng_valid_i in the same cycle as the strobe is the packet's last byte. When a packet becomes the current one, pkt_rdy_o is 1 from the next cycle, and rx_evt_o is 1 for exactly that cycle.
- R3: A cpu_rd_i pulse while pkt_rdy_o=1 puts the next byte of the current packet on cpu_data_o in the following cycle, starting from byte 0. A read with no packet present, or past the packet's byte count, returns 0 and does not advance.
- R4: byte_cnt_o equals the byte count of the current packet while pkt_rdy_o=1 and is 0 otherwise.
- R5: A pkt_clr_i pulse while pkt_rdy_o=1 frees the current bank. With no other packet stored, pkt_rdy_o is 0 in the next cycle.
- R6: With two packets stored, a release keeps pkt_rdy_o at 1, raises rx_evt_o for one cycle, and switches byte_cnt_o and subsequent reads to the second packet.
- R7: fifo_full_o is 1 exactly while two packets are stored (double buffering only), and eng_rdy_o is 0 while it is 1.
- R8: With dbl_buf_i=0, eng_rdy_o is 0 while one packet is stored, and bytes and strobes offered then are ignored.
- R9: With auto_clr_i=1, the read that brings the number of bytes read to max_pkt_i releases the packet at the same edge, as a pkt_clr_i pulse would.
- R10: A packet ended with eng_bad_i=1 is discarded. It raises neither pkt_rdy_o nor rx_evt_o and does not disturb the next packet.
- R11: A packet with more than PKT_BYTES bytes is discarded.
- R12: An end-of-packet strobe with no data bytes stores a zero-length packet with byte count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbl_buf_i | input | 1 | Double buffering enable (change only when empty) |
| auto_clr_i | input | 1 | Auto-release after max_pkt_i bytes read |
| max_pkt_i | input | CNT_W | Programmed maximum packet size |
| eng_valid_i | input | 1 | Engine data byte strobe |
| eng_data_i | input | DATA_W | Engine data byte |
| eng_eop_i | input | 1 | Engine end-of-packet strobe |
| eng_bad_i | input | 1 | Packet is bad, qualifies eng_eop_i |
| eng_rdy_o | output | 1 | Buffer can accept a packet; low means refuse |
| cpu_rd_i | input | 1 | CPU data register read strobe |
| cpu_data_o | output | DATA_W | Byte returned by the last read |
| pkt_clr_i | input | 1 | Software release of the current packet |
| pkt_rdy_o | output | 1 | A complete packet is available |
| byte_cnt_o | output | CNT_W | Byte count of the current packet |
| fifo_full_o | output | 1 | Two packets stored |
| rx_evt_o | output | 1 | One-cycle pulse when a packet becomes current |

## Verification
The checker holds on every cycle that a receive event only appears with a packet present, that a rise of packet-ready always comes with an event, and that the full flag implies a present packet and a refusing engine port. It also holds that a release while full hands over at once to the next packet, that single-buffer mode refuses while occupied, that a bad end-of-packet into an empty buffer leaves it empty, and that a read with nothing present returns zero. Byte order across banks, count values, auto-release at the exact byte, overrun discard and zero-length packets depend on data history, so only the directed scenarios show them.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_ONE   = 2'd1,
    OCC_TWO   = 2'd2
  } occ_e;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wbank_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rbank_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && (wbank_i == 1'(b))) mem[waddr_i] <= wdata_i;
    end
    assign bank_rd[b] = mem[raddr_i];
  end

  assign rdata_o = bank_rd[rbank_i];
endmodule

// File: rtl/rxb_fill.sv
module rxb_fill #(
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rdy_i,
  input  logic             valid_i,
  input  logic             eop_i,
  input  logic             bad_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] commit_len_o
);
  logic [CNT_W-1:0] wr_cnt_q;
  logic             ovr_q;
  logic             acc_byte, acc_eop, room, ovr_now;

  assign acc_byte     = valid_i && rdy_i;
  assign acc_eop      = eop_i && rdy_i;
  assign room         = wr_cnt_q < CNT_W'(DEPTH);
  assign we_o         = acc_byte && room;
  assign waddr_o      = wr_cnt_q[AW-1:0];
  assign ovr_now      = ovr_q || (acc_byte && !room);
  assign commit_o     = acc_eop && !bad_i && !ovr_now;
  assign commit_len_o = wr_cnt_q + CNT_W'(we_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      ovr_q    <= 1'b0;
    end else if (acc_eop) begin
      wr_cnt_q <= '0;
      ovr_q    <= 1'b0;
    end else if (we_o) begin
      wr_cnt_q <= wr_cnt_q + CNT_W'(1);
    end else if (acc_byte) begin
      ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbl_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] commit_len_i,
  input  logic             release_i,
  output logic             wbank_o,
  output logic             rbank_o,
  output logic             pkt_rdy_o,
  output logic             full_o,
  output logic             eng_rdy_o,
  output logic [CNT_W-1:0] cur_len_o,
  output logic             evt_o
);
  occ_e             occ_q, occ_d;
  logic             wbank_q, rbank_q, evt_q, evt_d;
  logic [CNT_W-1:0] len_q [2];

  always_comb begin
    occ_d = occ_q;
    unique case ({commit_i, release_i})
      2'b10: occ_d = (occ_q == OCC_EMPTY) ? OCC_ONE : OCC_TWO;
      2'b01: occ_d = (occ_q == OCC_TWO) ? OCC_ONE : OCC_EMPTY;
      default: occ_d = occ_q;
    endcase
  end

  // new current packet: arrival into empty, arrival replacing a released one, or hand-over
  assign evt_d = (commit_i && (occ_q == OCC_EMPTY || (occ_q == OCC_ONE && release_i)))
              || (release_i && occ_q == OCC_TWO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q   <= OCC_EMPTY;
      wbank_q <= 1'b0;
      rbank_q <= 1'b0;
      evt_q   <= 1'b0;
      len_q   <= '{default: '0};
    end else begin
      occ_q <= occ_d;
      evt_q <= evt_d;
      if (commit_i) begin
        len_q[wbank_q] <= commit_len_i;
        wbank_q        <= ~wbank_q;
      end
      if (release_i) rbank_q <= ~rbank_q;
    end
  end

  assign wbank_o   = wbank_q;
  assign rbank_o   = rbank_q;
  assign pkt_rdy_o = occ_q != OCC_EMPTY;
  assign full_o    = occ_q == OCC_TWO;
  assign eng_rdy_o = dbl_i ? (occ_q != OCC_TWO) : (occ_q == OCC_EMPTY);
  assign cur_len_o = len_q[rbank_q];
  assign evt_o     = evt_q;
endmodule

// File: rtl/rxb_drain.sv
module rxb_drain #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              clr_i,
  input  logic              auto_i,
  input  logic [CNT_W-1:0]  max_i,
  input  logic              pkt_rdy_i,
  input  logic [CNT_W-1:0]  cur_len_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic              release_o,
  output logic [DATA_W-1:0] data_o
);
  logic [CNT_W-1:0]  rd_ptr_q;
  logic [DATA_W-1:0] data_q;
  logic              rd_ok, auto_hit;

  assign rd_ok     = rd_i && pkt_rdy_i && (rd_ptr_q < cur_len_i);
  assign raddr_o   = rd_ptr_q[AW-1:0];
  assign auto_hit  = auto_i && rd_ok && ((rd_ptr_q + CNT_W'(1)) == max_i);
  assign release_o = (clr_i && pkt_rdy_i) || auto_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      data_q   <= '0;
    end else begin
      if (release_o)  rd_ptr_q <= '0;
      else if (rd_ok) rd_ptr_q <= rd_ptr_q + CNT_W'(1);
      if (rd_i) data_q <= rd_ok ? rdata_i : '0;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/rx_pkt_buf.sv
module rx_pkt_buf #(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 64,
  localparam int AW       = $clog2(PKT_BYTES),
  localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbl_buf_i,
  input  logic              auto_clr_i,
  input  logic [CNT_W-1:0]  max_pkt_i,
  input  logic              eng_valid_i,
  input  logic [DATA_W-1:0] eng_data_i,
  input  logic              eng_eop_i,
  input  logic              eng_bad_i,
  output logic              eng_rdy_o,
  input  logic              cpu_rd_i,
  output logic [DATA_W-1:0] cpu_data_o,
  input  logic              pkt_clr_i,
  output logic              pkt_rdy_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              fifo_full_o,
  output logic              rx_evt_o
);
  logic              we, commit, release_pkt, wbank, rbank, pkt_rdy, eng_rdy;
  logic [AW-1:0]     waddr, raddr;
  logic [CNT_W-1:0]  commit_len, cur_len;
  logic [DATA_W-1:0] rdata;

  rxb_fill #(.DEPTH(PKT_BYTES)) u_fill (
    .clk_i, .rst_ni,
    .rdy_i(eng_rdy), .valid_i(eng_valid_i), .eop_i(eng_eop_i), .bad_i(eng_bad_i),
    .we_o(we), .waddr_o(waddr), .commit_o(commit), .commit_len_o(commit_len)
  );

  rxb_store #(.DATA_W(DATA_W), .DEPTH(PKT_BYTES)) u_store (
    .clk_i, .we_i(we), .wbank_i(wbank), .waddr_i(waddr), .wdata_i(eng_data_i),
    .rbank_i(rbank), .raddr_i(raddr), .rdata_o(rdata)
  );

  rxb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .dbl_i(dbl_buf_i),
    .commit_i(commit), .commit_len_i(commit_len), .release_i(release_pkt),
    .wbank_o(wbank), .rbank_o(rbank), .pkt_rdy_o(pkt_rdy), .full_o(fifo_full_o),
    .eng_rdy_o(eng_rdy), .cur_len_o(cur_len), .evt_o(rx_evt_o)
  );

  rxb_drain #(.DATA_W(DATA_W), .DEPTH(PKT_BYTES)) u_drain (
    .clk_i, .rst_ni, .rd_i(cpu_rd_i), .clr_i(pkt_clr_i), .auto_i(auto_clr_i),
    .max_i(max_pkt_i), .pkt_rdy_i(pkt_rdy), .cur_len_i(cur_len), .rdata_i(rdata),
    .raddr_o(raddr), .release_o(release_pkt), .data_o(cpu_data_o)
  );

  assign pkt_rdy_o  = pkt_rdy;
  assign eng_rdy_o  = eng_rdy;
  assign byte_cnt_o = pkt_rdy ? cur_len : '0;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbl_buf_i,
  input logic              eng_eop_i,
  input logic              eng_bad_i,
  input logic              eng_rdy_o,
  input logic              cpu_rd_i,
  input logic [DATA_W-1:0] cpu_data_o,
  input logic              pkt_clr_i,
  input logic              pkt_rdy_o,
  input logic              fifo_full_o,
  input logic              rx_evt_o
);
  p_evt_has_pkt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_o |-> pkt_rdy_o);

  p_rise_evt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_rdy_o) |-> rx_evt_o);

  p_empty_read_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && !pkt_rdy_o) |=> (cpu_data_o == '0));

  p_handover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && pkt_clr_i) |=> (pkt_rdy_o && rx_evt_o && !fifo_full_o));

  p_full_refuse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> (pkt_rdy_o && !eng_rdy_o));

  p_single_refuse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbl_buf_i && pkt_rdy_o) |-> !eng_rdy_o);

  p_bad_dropped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_rdy_o && eng_eop_i && eng_bad_i) |=> !pkt_rdy_o);
endmodule

bind rx_pkt_buf rxb_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rxb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .dbl_buf_i(dbl_buf_i),
  .eng_eop_i(eng_eop_i), .eng_bad_i(eng_bad_i), .eng_rdy_o(eng_rdy_o),
  .cpu_rd_i(cpu_rd_i), .cpu_data_o(cpu_data_o), .pkt_clr_i(pkt_clr_i),
  .pkt_rdy_o(pkt_rdy_o), .fifo_full_o(fifo_full_o), .rx_evt_o(rx_evt_o)
);

// File: tb/rx_pkt_buf_bench.sv
`timescale 1ns/1ps
module rx_pkt_buf_bench;
  localparam int DW = 8;
  localparam int PB = 64;
  localparam int CW = $clog2(PB + 1);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          dbl = 1'b0, auto_clr = 1'b0;
  logic [CW-1:0] max_pkt = '0;
  logic          e_valid = 1'b0, e_eop = 1'b0, e_bad = 1'b0;
  logic [DW-1:0] e_data = '0;
  logic          e_rdy, rd = 1'b0, clr = 1'b0;
  logic [DW-1:0] rdata;
  logic          prdy, full, evt;
  logic [CW-1:0] cnt;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  rx_pkt_buf #(.DATA_W(DW), .PKT_BYTES(PB)) u_rx_pkt_buf (
    .clk_i(clk), .rst_ni(rst_n), .dbl_buf_i(dbl), .auto_clr_i(auto_clr),
    .max_pkt_i(max_pkt), .eng_valid_i(e_valid), .eng_data_i(e_data),
    .eng_eop_i(e_eop), .eng_bad_i(e_bad), .eng_rdy_o(e_rdy),
    .cpu_rd_i(rd), .cpu_data_o(rdata), .pkt_clr_i(clr), .pkt_rdy_o(prdy),
    .byte_cnt_o(cnt), .fifo_full_o(full), .rx_evt_o(evt)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // bytes base+i; eop on the last byte (alone when len==0); returns at the sample point after commit
  task automatic send(input int len, input int base, input bit is_bad);
    if (len == 0) begin
      @(negedge clk); e_eop = 1'b1; e_bad = is_bad;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      e_valid = 1'b1; e_data = DW'(base + i);
      e_eop = (i == len - 1); e_bad = is_bad && (i == len - 1);
    end
    @(negedge clk);
    e_valid = 1'b0; e_eop = 1'b0; e_bad = 1'b0;
  endtask

  task automatic read_byte(output int v);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = int'(rdata);
  endtask

  task automatic release_pkt();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pkt_rdy", int'(prdy), 0);
    check("R1 full", int'(full), 0);
    check("R1 evt", int'(evt), 0);
    check("R1 eng_rdy", int'(e_rdy), 1);
    check("R1 data", int'(rdata), 0);
    check("R4 cnt idle", int'(cnt), 0);
  endtask

  task automatic t_single();
    int v;
    dbl = 1'b0;
    send(5, 'h10, 1'b0);
    check("R2 pkt_rdy", int'(prdy), 1);
    check("R2 evt", int'(evt), 1);
    check("R4 cnt", int'(cnt), 5);
    @(negedge clk);
    check("R2 evt one cycle", int'(evt), 0);
    check("R8 eng_rdy low", int'(e_rdy), 0);
    send(3, 'h50, 1'b0);
    check("R8 ignored cnt", int'(cnt), 5);
    for (int i = 0; i < 5; i++) begin
      read_byte(v);
      check("R3 byte", v, 'h10 + i);
    end
    read_byte(v);
    check("R3 past end", v, 0);
    release_pkt();
    check("R5 pkt_rdy", int'(prdy), 0);
    check("R4 cnt after clr", int'(cnt), 0);
    check("R5 eng_rdy", int'(e_rdy), 1);
    check("R8 nothing stored", int'(prdy), 0);
    read_byte(v);
    check("R3 empty read", v, 0);
  endtask

  task automatic t_double();
    int v;
    dbl = 1'b1;
    send(4, 'h20, 1'b0);
    check("R7 not full", int'(full), 0);
    check("R7 eng_rdy one", int'(e_rdy), 1);
    send(3, 'h40, 1'b0);
    check("R6 no evt for second", int'(evt), 0);
    check("R7 full", int'(full), 1);
    check("R7 eng_rdy", int'(e_rdy), 0);
    check("R6 cnt first", int'(cnt), 4);
    read_byte(v); check("R3 A0", v, 'h20);
    read_byte(v); check("R3 A1", v, 'h21);
    release_pkt();
    check("R6 pkt_rdy held", int'(prdy), 1);
    check("R6 evt", int'(evt), 1);
    check("R6 cnt second", int'(cnt), 3);
    check("R7 full cleared", int'(full), 0);
    for (int i = 0; i < 3; i++) begin
      read_byte(v);
      check("R6 B byte", v, 'h40 + i);
    end
    release_pkt();
    check("R5 empty", int'(prdy), 0);
  endtask

  task automatic t_auto();
    int v;
    dbl = 1'b1; auto_clr = 1'b1; max_pkt = CW'(4);
    send(4, 'h60, 1'b0);
    send(4, 'h70, 1'b0);
    for (int i = 0; i < 4; i++) begin
      read_byte(v);
      check("R9 A byte", v, 'h60 + i);
    end
    check("R9 next current", int'(prdy), 1);
    check("R9 evt", int'(evt), 1);
    check("R9 full gone", int'(full), 0);
    read_byte(v); check("R9 B0", v, 'h70);
    for (int i = 1; i < 4; i++) read_byte(v);
    check("R9 B3", v, 'h73);
    check("R9 released", int'(prdy), 0);
    auto_clr = 1'b0;
  endtask

  task automatic t_bad();
    int v;
    send(3, 'h90, 1'b1);
    check("R10 no pkt", int'(prdy), 0);
    check("R10 no evt", int'(evt), 0);
    send(2, 'h80, 1'b0);
    check("R10 next cnt", int'(cnt), 2);
    read_byte(v); check("R10 next data", v, 'h80);
    release_pkt();
  endtask

  task automatic t_overrun();
    int v;
    send(PB + 1, 'h00, 1'b0);
    check("R11 dropped", int'(prdy), 0);
    send(PB, 'h05, 1'b0);
    check("R11 full-size kept", int'(cnt), PB);
    read_byte(v); check("R11 first byte", v, 'h05);
    release_pkt();
  endtask

  task automatic t_zero();
    int v;
    send(0, 0, 1'b0);
    check("R12 pkt_rdy", int'(prdy), 1);
    check("R12 evt", int'(evt), 1);
    check("R12 cnt", int'(cnt), 0);
    read_byte(v); check("R12 read", v, 0);
    release_pkt();
    check("R12 released", int'(prdy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_double();
    t_auto();
    t_bad();
    t_overrun();
    t_zero();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule